// File: doc/BRIEF.md
# DDR2 Memory Test Traffic Generator

This block exercises a DDR2 memory through the user-side FIFOs of its controller. After a start pulse it runs a write pass and then a read pass over the same addresses. In the write pass it pushes each burst's data words into the write-data FIFO and then the write command into the command FIFO. In the read pass it reissues the same addresses as read commands and pops the returned words. It rebuilds each expected word from the address and beat index and compares it with the returned word. A mismatch raises a sticky error flag. A single-cycle done pulse marks the end of the run.

Each command address selects one 64-bit memory word. Each 128-bit data-FIFO word carries two such words, with the rising-edge beat in the low half. The burst length (4 or 8) sets how many data words go with each command. The stride mode sets how far the address moves per command: either a dense stride that covers exactly one burst, or a fixed stride of 8 that works with both burst lengths.

Top module: `memtest_gen`

## Requirements
- R1: While reset is held and after it is released, cmd_wr_en, wdf_wr_en, rdf_rd_en, done and err are all low until start is given.
- R2: Each command entry is 36 bits: bits 35:33 hold the operation code (000 for write, 001 for read) and bits 32:0 hold the address.
- R3: With burst8 low each command carries 2 data words; with burst8 high it carries 4. All data words of a write burst are pushed before that burst's write command.
- R4: The first command of each pass uses address 0. In dense mode (fixed_stride low) the address rises by 4 per command for burst length 4 and by 8 for burst length 8. With fixed_stride high it rises by 8 for both burst lengths, so with burst length 4 the words at offsets 4 to 7 of each 8-word region are never written.
- R5: Data word j (counted from 0) of the burst at address A is {P(A+2j+1), P(A+2j)}. Here P(m) is {~m[31:0], m[31:0]} XOR {m[32], 63 zero bits}.
- R6: No command is pushed while cmd_afull is high. No write data is pushed while wdf_afull is high. No read word is popped while rdf_empty is high.
- R7: After cmd_total write commands, exactly cmd_total read commands follow on the same address sequence. Each read command pops the burst's number of data words (2 or 4).
- R8: err is set by the first returned word that differs from its expected value. It stays set until the next accepted start, which clears it.
- R9: done is high for exactly one cycle, in the cycle after the last read word is popped. With cmd_total equal to 0, done comes in the cycle after start and nothing is pushed.
- R10: A start pulse during a run has no effect on that run.
- R11: burst8, fixed_stride and cmd_total are sampled when start is accepted. Changing them during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| burst8 | input | 1 | 1: burst length 8, 0: burst length 4 |
| fixed_stride | input | 1 | 1: address stride 8 for both burst lengths |
| cmd_total | input | CNT_W | Number of commands per pass |
| cmd_afull | input | 1 | Command FIFO almost full |
| cmd_wr_en | output | 1 | Command FIFO write strobe |
| cmd_data | output | 36 | Command entry {code, address} |
| wdf_afull | input | 1 | Write-data FIFO almost full |
| wdf_wr_en | output | 1 | Write-data FIFO write strobe |
| wdf_data | output | 128 | Write-data word |
| rdf_empty | input | 1 | Read-data FIFO empty |
| rdf_data | input | 128 | Head word of the read-data FIFO |
| rdf_rd_en | output | 1 | Read-data FIFO pop strobe |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky data mismatch flag |

## Verification
A wrong beat count or address register shows up within one burst. The command entries carry wrong addresses, or a write command follows the wrong number of data words. The bench compares both against its own address and beat arithmetic at every push. A wrong pattern value or a bad compare shows at err right after the first corrupted or clean read word. A stuck or mis-sequenced state machine shows as a done pulse that comes late, never comes, or comes with the wrong number of commands or pops behind it. Backpressure patterns on all three FIFO flags expose any push or pop made while a flag forbids it, in the very cycle it happens.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
  localparam int CODE_W = 3;
  localparam int ADDR_W = 33;
  localparam int CMD_W  = CODE_W + ADDR_W;
  localparam int HALF_W = 64;
  localparam int DATA_W = 2 * HALF_W;
  localparam int BEAT_W = 2;
  localparam int KW_W   = BEAT_W + 1;
  localparam int STR_W  = 4;

  localparam logic [CODE_W-1:0] OP_WRITE = 3'b000;
  localparam logic [CODE_W-1:0] OP_READ  = 3'b001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WDATA,
    ST_WCMD,
    ST_RCMD,
    ST_RDATA,
    ST_DONE
  } gen_state_t;

  // data-FIFO words per command
  function automatic logic [KW_W-1:0] words_per_cmd(input logic b8);
    return b8 ? KW_W'(4) : KW_W'(2);
  endfunction

  // address step per command, in 64-bit memory words
  function automatic logic [STR_W-1:0] stride_of(input logic b8, input logic fix8);
    return (fix8 || b8) ? STR_W'(8) : STR_W'(4);
  endfunction

  // value stored at one 64-bit memory word
  function automatic logic [HALF_W-1:0] mem_word(input logic [ADDR_W-1:0] m);
    return {~m[31:0], m[31:0]} ^ {m[32], 63'b0};
  endfunction

  // one 128-bit FIFO word: rising beat low, falling beat high
  function automatic logic [DATA_W-1:0] beat_pattern(input logic [ADDR_W-1:0] a,
                                                     input logic [BEAT_W-1:0] j);
    logic [ADDR_W-1:0] lo_m;
    logic [ADDR_W-1:0] hi_m;
    lo_m = a + ADDR_W'({j, 1'b0});
    hi_m = lo_m + ADDR_W'(1);
    return {mem_word(hi_m), mem_word(lo_m)};
  endfunction
endpackage

// File: rtl/memtest_addr_seq.sv
module memtest_addr_seq
  import memtest_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [STR_W-1:0]  stride,
  input  logic [CNT_W-1:0]  total,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] total_m1;

  assign total_m1 = total - CNT_W'(1);
  assign last     = (idx == total_m1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      addr <= '0;
      idx  <= '0;
    end else if (step) begin
      addr <= addr + ADDR_W'(stride);
      idx  <= idx + CNT_W'(1);
    end
  end
endmodule

// File: rtl/memtest_beat_ctr.sv
module memtest_beat_ctr
  import memtest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [KW_W-1:0]   words,
  output logic [BEAT_W-1:0] beat,
  output logic              last
);
  assign last = ({1'b0, beat} == (words - KW_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      beat <= '0;
    end else if (step) begin
      beat <= last ? '0 : beat + BEAT_W'(1);
    end
  end
endmodule

// File: rtl/memtest_rd_check.sv
module memtest_rd_check
  import memtest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              valid,
  input  logic [DATA_W-1:0] actual,
  input  logic [DATA_W-1:0] expected,
  output logic              mismatch,
  output logic              err
);
  assign mismatch = valid && (actual != expected);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      err <= 1'b0;
    end else if (mismatch) begin
      err <= 1'b1;
    end
  end
endmodule

// File: rtl/memtest_gen.sv
module memtest_gen
  import memtest_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              burst8,
  input  logic              fixed_stride,
  input  logic [CNT_W-1:0]  cmd_total,
  input  logic              cmd_afull,
  output logic              cmd_wr_en,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              wdf_afull,
  output logic              wdf_wr_en,
  output logic [DATA_W-1:0] wdf_data,
  input  logic              rdf_empty,
  input  logic [DATA_W-1:0] rdf_data,
  output logic              rdf_rd_en,
  output logic              done,
  output logic              err
);
  gen_state_t        state, state_nx;
  logic              cfg_b8, cfg_fix;
  logic [CNT_W-1:0]  cfg_total;

  logic [KW_W-1:0]   words_k;
  logic [STR_W-1:0]  stride;
  logic [ADDR_W-1:0] addr;
  logic [BEAT_W-1:0] beat;
  logic              last_cmd, last_beat;
  logic [DATA_W-1:0] expect_word;

  // named internal events
  logic start_accept, wdf_push, cmd_push, rdf_pop;
  logic wr_last_cmd, rd_burst_end, seq_clear, seq_step;
  logic beat_step, data_mismatch;

  assign words_k     = words_per_cmd(cfg_b8);
  assign stride      = stride_of(cfg_b8, cfg_fix);
  assign expect_word = beat_pattern(addr, beat);

  assign start_accept = (state == ST_IDLE) && start;
  assign wdf_push     = (state == ST_WDATA) && !wdf_afull;
  assign cmd_push     = ((state == ST_WCMD) || (state == ST_RCMD)) && !cmd_afull;
  assign rdf_pop      = (state == ST_RDATA) && !rdf_empty;
  assign beat_step    = wdf_push || rdf_pop;
  assign wr_last_cmd  = (state == ST_WCMD) && cmd_push && last_cmd;
  assign rd_burst_end = rdf_pop && last_beat;
  assign seq_clear    = start_accept || wr_last_cmd;
  assign seq_step     = ((state == ST_WCMD) && cmd_push && !last_cmd) ||
                        (rd_burst_end && !last_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cfg_b8    <= 1'b0;
      cfg_fix   <= 1'b0;
      cfg_total <= '0;
    end else begin
      state <= state_nx;
      if (start_accept) begin
        cfg_b8    <= burst8;
        cfg_fix   <= fixed_stride;
        cfg_total <= cmd_total;
      end
    end
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = (cmd_total == '0) ? ST_DONE : ST_WDATA;
      ST_WDATA: if (wdf_push && last_beat) state_nx = ST_WCMD;
      ST_WCMD:  if (cmd_push) state_nx = last_cmd ? ST_RCMD : ST_WDATA;
      ST_RCMD:  if (cmd_push) state_nx = ST_RDATA;
      ST_RDATA: if (rd_burst_end) state_nx = last_cmd ? ST_DONE : ST_RCMD;
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  memtest_addr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (seq_clear),
    .step   (seq_step),
    .stride (stride),
    .total  (cfg_total),
    .addr   (addr),
    .last   (last_cmd)
  );

  memtest_beat_ctr u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_accept),
    .step  (beat_step),
    .words (words_k),
    .beat  (beat),
    .last  (last_beat)
  );

  memtest_rd_check u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_accept),
    .valid    (rdf_pop),
    .actual   (rdf_data),
    .expected (expect_word),
    .mismatch (data_mismatch),
    .err      (err)
  );

  assign cmd_wr_en = cmd_push;
  assign cmd_data  = {(state == ST_RCMD) ? OP_READ : OP_WRITE, addr};
  assign wdf_wr_en = wdf_push;
  assign wdf_data  = expect_word;
  assign rdf_rd_en = rdf_pop;
  assign done      = (state == ST_DONE);
endmodule

// File: rtl/memtest_sva.sv
module memtest_sva
  import memtest_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_accept,
  input logic             cmd_wr_en,
  input logic             cmd_afull,
  input logic [CMD_W-1:0] cmd_data,
  input logic             wdf_wr_en,
  input logic             wdf_afull,
  input logic             rdf_rd_en,
  input logic             rdf_empty,
  input logic             done,
  input logic             err
);
  p_no_cmd_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_en |-> !cmd_afull);
  p_no_wdf_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdf_wr_en |-> !wdf_afull);
  p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdf_rd_en |-> !rdf_empty);
  p_cmd_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_en |-> (cmd_data[CMD_W-1:CMD_W-2] == 2'b00));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(cmd_wr_en || wdf_wr_en || rdf_rd_en));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start_accept) |=> err);
  p_err_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> !err);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wr_en, wdf_wr_en, rdf_rd_en}));
endmodule

bind memtest_gen memtest_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_accept (start_accept),
  .cmd_wr_en    (cmd_wr_en),
  .cmd_afull    (cmd_afull),
  .cmd_data     (cmd_data),
  .wdf_wr_en    (wdf_wr_en),
  .wdf_afull    (wdf_afull),
  .rdf_rd_en    (rdf_rd_en),
  .rdf_empty    (rdf_empty),
  .done         (done),
  .err          (err)
);

// File: tb/memtest_gen_bench.sv
module memtest_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int MEM_N      = 1024;
  localparam int NROWS      = 6;
  localparam logic [63:0] SENTINEL = 64'hDEAD_BEEF_0BAD_F00D;

  typedef struct packed {
    logic       b8;
    logic       fx;
    logic [7:0] n;
    logic [7:0] cor;   // 255 = no corruption
    logic       bp;
    logic       eerr;
  } vec_t;

  localparam vec_t VECS [NROWS] = '{
    '{1'b0, 1'b0, 8'd5, 8'd255, 1'b0, 1'b0},
    '{1'b1, 1'b0, 8'd4, 8'd255, 1'b1, 1'b0},
    '{1'b0, 1'b1, 8'd3, 8'd255, 1'b1, 1'b0},
    '{1'b1, 1'b1, 8'd6, 8'd9,   1'b1, 1'b1},
    '{1'b0, 1'b0, 8'd7, 8'd255, 1'b1, 1'b0},
    '{1'b0, 1'b0, 8'd2, 8'd0,   1'b0, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             burst8 = 1'b0;
  logic             fixed_stride = 1'b0;
  logic [CNT_W-1:0] cmd_total = '0;
  logic             cmd_afull = 1'b0;
  logic             cmd_wr_en;
  logic [35:0]      cmd_data;
  logic             wdf_afull = 1'b0;
  logic             wdf_wr_en;
  logic [127:0]     wdf_data;
  logic             rdf_empty = 1'b1;
  logic [127:0]     rdf_data = '0;
  logic             rdf_rd_en;
  logic             done;
  logic             err;

  memtest_gen #(.CNT_W(CNT_W)) u_memtest_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .burst8(burst8),
    .fixed_stride(fixed_stride), .cmd_total(cmd_total),
    .cmd_afull(cmd_afull), .cmd_wr_en(cmd_wr_en), .cmd_data(cmd_data),
    .wdf_afull(wdf_afull), .wdf_wr_en(wdf_wr_en), .wdf_data(wdf_data),
    .rdf_empty(rdf_empty), .rdf_data(rdf_data), .rdf_rd_en(rdf_rd_en),
    .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // model state
  logic [63:0]  mem [MEM_N];
  logic [127:0] wq[$];
  logic [127:0] rq[$];
  int cyc = 0;
  int cur_k = 2, cur_stride = 4, cur_n = 1, cur_cor = 255;
  logic cur_bp = 1'b0;
  int cmd_cnt, wd_cnt, pop_cnt, rd_word_cnt, done_cnt;
  int cmd_bad, pat_bad, order_bad, viol;

  function automatic logic [63:0] ref_word(input longint unsigned m);
    logic [31:0] lo;
    lo = m[31:0];
    return {~lo, lo};
  endfunction

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    cmd_cnt = 0; wd_cnt = 0; pop_cnt = 0; rd_word_cnt = 0; done_cnt = 0;
    cmd_bad = 0; pat_bad = 0; order_bad = 0; viol = 0;
    wq.delete(); rq.delete();
    for (int i = 0; i < MEM_N; i++) mem[i] = SENTINEL;
  endtask

  // FIFO and memory model: drive at falling edge, observe 1 time unit later
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      cmd_afull = cur_bp && (cyc % 5 == 1);
      wdf_afull = cur_bp && (cyc % 3 == 0);
      rdf_empty = (rq.size() == 0) || (cur_bp && (cyc % 4 == 2));
      rdf_data  = (rq.size() != 0) ? rq[0] : '0;
      #1;
      if (wdf_wr_en) begin
        int c, j;
        longint unsigned a;
        if (wdf_afull) viol++;
        c = wd_cnt / cur_k;
        j = wd_cnt % cur_k;
        a = longint'(c) * cur_stride + 2 * j;
        if (wdf_data != {ref_word(a + 1), ref_word(a)}) pat_bad++;
        wq.push_back(wdf_data);
        wd_cnt++;
      end
      if (cmd_wr_en) begin
        int a;
        logic [2:0] code;
        if (cmd_afull) viol++;
        code = (cmd_cnt < cur_n) ? 3'b000 : 3'b001;
        a    = (cmd_cnt % cur_n) * cur_stride;
        if (cmd_data != {code, 33'(a)}) cmd_bad++;
        if (cmd_data[35:33] == 3'b000) begin
          if (wq.size() != cur_k) order_bad++;
          for (int b = 0; b < cur_k && b < wq.size(); b++) begin
            mem[(a + 2*b) % MEM_N]     = wq[b][63:0];
            mem[(a + 2*b + 1) % MEM_N] = wq[b][127:64];
          end
          wq.delete();
        end else begin
          for (int b = 0; b < cur_k; b++) begin
            logic [127:0] w;
            w = {mem[(a + 2*b + 1) % MEM_N], mem[(a + 2*b) % MEM_N]};
            if (rd_word_cnt == cur_cor) w[5] = ~w[5];
            rq.push_back(w);
            rd_word_cnt++;
          end
        end
        cmd_cnt++;
      end
      if (rdf_rd_en) begin
        if (rdf_empty) viol++;
        else void'(rq.pop_front());
        pop_cnt++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    clear_model();
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset outputs", {cmd_wr_en, wdf_wr_en, rdf_rd_en, done, err} == 5'b0,
        {cmd_wr_en, wdf_wr_en, rdf_rd_en, done, err}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 idle after reset", {cmd_wr_en, wdf_wr_en, rdf_rd_en, done, err} == 5'b0,
        {cmd_wr_en, wdf_wr_en, rdf_rd_en, done, err}, 0);

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      int tmo;
      vec_t v;
      v = VECS[r];
      @(negedge clk);
      clear_model();
      cur_k = v.b8 ? 4 : 2;
      cur_stride = (v.b8 || v.fx) ? 8 : 4;
      cur_n = v.n; cur_cor = v.cor; cur_bp = v.bp;
      burst8 = v.b8; fixed_stride = v.fx; cmd_total = CNT_W'(v.n);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      #2;
      chk("R8 err cleared by start", err == 1'b0, err, 0);
      // R10 / R11: start and config changes mid-run are ignored
      repeat (4) @(negedge clk);
      start = 1'b1; burst8 = ~v.b8; fixed_stride = ~v.fx; cmd_total = CNT_W'(v.n + 3);
      @(negedge clk); start = 1'b0;
      tmo = 0;
      while (done_cnt == 0 && tmo < 5000) begin
        @(negedge clk); #2; tmo++;
      end
      chk("R9 done reached", done_cnt == 1, done_cnt, 1);
      chk("R7 R10 command count", cmd_cnt == 2 * v.n, cmd_cnt, 2 * v.n);
      chk("R3 R11 write words", wd_cnt == v.n * cur_k, wd_cnt, v.n * cur_k);
      chk("R7 read pops", pop_cnt == v.n * cur_k, pop_cnt, v.n * cur_k);
      chk("R2 R4 command entries", cmd_bad == 0, cmd_bad, 0);
      chk("R5 write pattern", pat_bad == 0, pat_bad, 0);
      chk("R3 data before command", order_bad == 0, order_bad, 0);
      chk("R6 flag respect", viol == 0, viol, 0);
      chk("R8 err result", err == v.eerr, err, v.eerr);
      @(negedge clk); #2;
      chk("R9 done single cycle", done == 1'b0 && done_cnt == 1, done_cnt, 1);
      if (v.fx && !v.b8)
        chk("R4 gap untouched", mem[4] == SENTINEL && mem[12] == SENTINEL,
            (mem[4] == SENTINEL), 1);
      if (v.eerr) begin
        repeat (5) @(negedge clk);
        #2;
        chk("R8 err sticky when idle", err == 1'b1, err, 1);
      end
    end

    // R9: zero command count
    @(negedge clk);
    clear_model();
    cur_bp = 1'b0; cur_n = 1;
    cmd_total = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    #2;
    chk("R9 zero count done", done == 1'b1, done, 1);
    repeat (3) @(negedge clk);
    #2;
    chk("R9 zero count no traffic", cmd_cnt == 0 && wd_cnt == 0 && pop_cnt == 0,
        cmd_cnt + wd_cnt + pop_cnt, 0);

    finish_run();
  end
endmodule